// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits next to a 32-bit processor core and takes over the control-flow side of exceptions. Each cycle it looks at the pending causes: a reset request, an undefined-opcode flag, a software trap found in the executing instruction, prefetch and data aborts, and the normal and fast interrupt pins. It picks the most urgent cause and tells the core to redirect its PC to that cause's fixed vector. In the same clock edge it stores the old status word in the saved-status register of the mode it enters, stores the return address in that mode's link register, and moves the status word into the handler mode with the right interrupt masks set.

The block owns the current status word. The core can overwrite it through a write port to change mode or clear the masks. A return request, made while in an exception mode, redirects the PC to the banked link address and restores the saved status in the same step. The 24-bit immediate of the last software trap is held on an output so that handler code can dispatch on it without fetching the instruction again.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The redirect target is VEC_BASE plus 4 × cause code. The cause codes are: reset 0, undefined 1, software trap 2, prefetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7. Code 5 is never produced.
- R2: When causes coincide, the one taken is chosen in this order: reset request, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software trap, return. `cause_o` shows the code of the cause taken, 8 for a return, and 15 when there is no redirect.
- R3: A normal interrupt is taken only while status bit 7 is 0. A fast interrupt is taken only while status bit 6 is 0.
- R4: A software trap is recognised when `exec_i` is high and instruction bits 27:24 are 1111. Bits 31:28 have no effect on this.
- R5: On any entry other than reset, the status word as it stood before the entry is written to the saved-status register of the target mode. Status bits 4:0 then take the target mode: fast 0x11, normal interrupt 0x12, supervisor 0x13 (software trap), abort 0x17 (both aborts), undefined 0x1B. User mode is 0x10.
- R6: Every entry sets status bit 7. Fast interrupt entry also sets bit 6. All other status bits are kept.
- R7: On entry, the target mode's link register receives {pc_i[31:2],00} + 4. `link_o` and `saved_status_o` show the registers of the current mode, and read zero in a mode with no bank.
- R8: A reset request sets the status to 0x000000D3, redirects to VEC_BASE, clears the trap number and leaves every bank unchanged.
- R9: A return request in an exception mode redirects to that mode's link value and loads the status from that mode's saved status, both in one step. In a mode with no bank the request is ignored.
- R10: An exception taken in a cycle wins over a return request and over a status write made in the same cycle. Both of those then have no effect.
- R11: `trap_num_o` takes the immediate (bits 23:0) on software-trap entry. Any other exception entry clears it to zero. Otherwise it holds its value.
- R12: Bits 1:0 of `target_o` are always zero, whatever the low bits of `pc_i` are.
- R13: While `rst_ni` is low, the status is 0x000000D3, all banks and the trap number are zero, and no redirect is shown when no cause is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Reset exception request |
| undef_i | input | 1 | Undefined opcode flag |
| pabt_i | input | 1 | Prefetch abort flag |
| dabt_i | input | 1 | Data abort flag |
| irq_i | input | 1 | Normal interrupt request pin |
| fiq_i | input | 1 | Fast interrupt request pin |
| exec_i | input | 1 | `instr_i` is executing this cycle |
| instr_i | input | 32 | Executing instruction word |
| pc_i | input | 32 | Address of the current instruction |
| ret_i | input | 1 | Return-with-restore request |
| status_we_i | input | 1 | Status write enable |
| status_wd_i | input | 32 | Status write data |
| redirect_o | output | 1 | Core must load `target_o` into its PC |
| cause_o | output | 4 | Cause taken this cycle |
| target_o | output | 32 | New PC |
| status_o | output | 32 | Current status word |
| saved_status_o | output | 32 | Saved status of the current mode |
| link_o | output | 32 | Link register of the current mode |
| trap_num_o | output | 24 | Immediate of the last software trap |

## Verification
The collisions that matter are an exception arriving in the same cycle as a return request, and an exception arriving in the same cycle as a status write. Directed cases raise a fast interrupt while a return from the normal-interrupt handler is requested, and raise an undefined opcode together with a status write. The random phase also raises return, status writes and every cause independently. A reference model in the bench derives the winner from the priority list and then judges the redirect target, the resulting status word and the untouched banks of the losing operation.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;

  localparam int BIT_I     = 7;
  localparam int BIT_F     = 6;
  localparam int NUM_BANKS = 5;
  localparam int BANK_IW   = $clog2(NUM_BANKS);

  typedef enum logic [3:0] {
    CS_RESET = 4'd0,
    CS_UNDEF = 4'd1,
    CS_TRAP  = 4'd2,
    CS_PABT  = 4'd3,
    CS_DABT  = 4'd4,
    CS_IRQ   = 4'd6,
    CS_FIQ   = 4'd7,
    CS_RET   = 4'd8,
    CS_NONE  = 4'd15
  } cause_e;

  typedef struct packed {
    logic               hit;
    logic [BANK_IW-1:0] idx;
  } bank_sel_t;

  function automatic logic [4:0] cause_mode(cause_e c);
    case (c)
      CS_UNDEF:          return MODE_UND;
      CS_PABT, CS_DABT:  return MODE_ABT;
      CS_IRQ:            return MODE_IRQ;
      CS_FIQ:            return MODE_FIQ;
      default:           return MODE_SVC;
    endcase
  endfunction

  function automatic bank_sel_t mode_bank(logic [4:0] m);
    bank_sel_t s;
    s.hit = 1'b1;
    case (m)
      MODE_FIQ: s.idx = BANK_IW'(0);
      MODE_IRQ: s.idx = BANK_IW'(1);
      MODE_SVC: s.idx = BANK_IW'(2);
      MODE_ABT: s.idx = BANK_IW'(3);
      MODE_UND: s.idx = BANK_IW'(4);
      default: begin
        s.hit = 1'b0;
        s.idx = '0;
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/exc_trap_decode.sv
module exc_trap_decode #(
  parameter int IMM_W = 24
) (
  input  logic             exec_i,
  input  logic [3:0]       class_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             hit_o,
  output logic [IMM_W-1:0] imm_o
);
  assign hit_o = exec_i && (&class_i);
  assign imm_o = imm_i;
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
(
  input  logic   rst_req_i,
  input  logic   dabt_i,
  input  logic   fiq_i,
  input  logic   irq_i,
  input  logic   pabt_i,
  input  logic   undef_i,
  input  logic   trap_i,
  input  logic   ret_ok_i,
  input  logic   i_mask_i,
  input  logic   f_mask_i,
  output logic   take_o,
  output cause_e cause_o
);
  always_comb begin
    take_o  = 1'b1;
    cause_o = CS_NONE;
    if (rst_req_i)                 cause_o = CS_RESET;
    else if (dabt_i)               cause_o = CS_DABT;
    else if (fiq_i && !f_mask_i)   cause_o = CS_FIQ;
    else if (irq_i && !i_mask_i)   cause_o = CS_IRQ;
    else if (pabt_i)               cause_o = CS_PABT;
    else if (undef_i)              cause_o = CS_UNDEF;
    else if (trap_i)               cause_o = CS_TRAP;
    else if (ret_ok_i)             cause_o = CS_RET;
    else                           take_o  = 1'b0;
  end
endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file #(
  parameter int XLEN = 32,
  parameter int NB   = 5,
  localparam int IW  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [IW-1:0]   wr_idx_i,
  input  logic [XLEN-1:0] spsr_wd_i,
  input  logic [XLEN-1:0] lr_wd_i,
  input  logic            rd_hit_i,
  input  logic [IW-1:0]   rd_idx_i,
  output logic [XLEN-1:0] spsr_rd_o,
  output logic [XLEN-1:0] lr_rd_o
);
  logic [XLEN-1:0] spsr_q [NB];
  logic [XLEN-1:0] lr_q   [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        spsr_q[g] <= '0;
        lr_q[g]   <= '0;
      end else if (wr_en_i && (wr_idx_i == IW'(g))) begin
        spsr_q[g] <= spsr_wd_i;
        lr_q[g]   <= lr_wd_i;
      end
    end
  end

  logic rd_ok;
  assign rd_ok     = rd_hit_i && (32'(rd_idx_i) < NB);
  assign spsr_rd_o = rd_ok ? spsr_q[rd_idx_i] : '0;
  assign lr_rd_o   = rd_ok ? lr_q[rd_idx_i]   : '0;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              IMM_W    = 24,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_req_i,
  input  logic             undef_i,
  input  logic             pabt_i,
  input  logic             dabt_i,
  input  logic             irq_i,
  input  logic             fiq_i,
  input  logic             exec_i,
  input  logic [XLEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             ret_i,
  input  logic             status_we_i,
  input  logic [XLEN-1:0]  status_wd_i,
  output logic             redirect_o,
  output logic [3:0]       cause_o,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  status_o,
  output logic [XLEN-1:0]  saved_status_o,
  output logic [XLEN-1:0]  link_o,
  output logic [IMM_W-1:0] trap_num_o
);
  localparam logic [XLEN-1:0] RST_STATUS = XLEN'({1'b1, 1'b1, 1'b0, MODE_SVC});

  logic [XLEN-1:0]  cpsr_q, cpsr_d;
  logic [IMM_W-1:0] trap_q, trap_d;

  logic             trap_hit;
  logic [IMM_W-1:0] trap_imm;
  logic             take;
  cause_e           cause;
  bank_sel_t        cur_sel, ent_sel;
  logic [4:0]       ent_mode;
  logic [XLEN-1:0]  spsr_rd, lr_rd, link_wd, entry_status, raw_target;
  logic             bank_we;
  logic             unused_bits;

  assign unused_bits = ^{instr_i[XLEN-1:28], pc_i[1:0]};

  exc_trap_decode #(.IMM_W(IMM_W)) u_trap (
    .exec_i  (exec_i),
    .class_i (instr_i[27:24]),
    .imm_i   (instr_i[IMM_W-1:0]),
    .hit_o   (trap_hit),
    .imm_o   (trap_imm)
  );

  assign cur_sel = mode_bank(cpsr_q[4:0]);

  exc_prio_sel u_prio (
    .rst_req_i (rst_req_i),
    .dabt_i    (dabt_i),
    .fiq_i     (fiq_i),
    .irq_i     (irq_i),
    .pabt_i    (pabt_i),
    .undef_i   (undef_i),
    .trap_i    (trap_hit),
    .ret_ok_i  (ret_i && cur_sel.hit),
    .i_mask_i  (cpsr_q[BIT_I]),
    .f_mask_i  (cpsr_q[BIT_F]),
    .take_o    (take),
    .cause_o   (cause)
  );

  assign ent_mode = cause_mode(cause);
  assign ent_sel  = mode_bank(ent_mode);
  assign link_wd  = {pc_i[XLEN-1:2], 2'b00} + XLEN'(4);
  assign bank_we  = take && (cause != CS_RESET) && (cause != CS_RET);

  exc_bank_file #(.XLEN(XLEN), .NB(NUM_BANKS)) u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (bank_we),
    .wr_idx_i  (ent_sel.idx),
    .spsr_wd_i (cpsr_q),
    .lr_wd_i   (link_wd),
    .rd_hit_i  (cur_sel.hit),
    .rd_idx_i  (cur_sel.idx),
    .spsr_rd_o (spsr_rd),
    .lr_rd_o   (lr_rd)
  );

  always_comb begin
    entry_status        = cpsr_q;
    entry_status[4:0]   = ent_mode;
    entry_status[BIT_I] = 1'b1;
    if (cause == CS_FIQ) entry_status[BIT_F] = 1'b1;
  end

  always_comb begin
    cpsr_d = cpsr_q;
    trap_d = trap_q;
    if (!take) begin
      if (status_we_i) cpsr_d = status_wd_i;
    end else begin
      case (cause)
        CS_RET:   cpsr_d = spsr_rd;
        CS_RESET: begin
          cpsr_d = RST_STATUS;
          trap_d = '0;
        end
        CS_TRAP: begin
          cpsr_d = entry_status;
          trap_d = trap_imm;
        end
        default: begin
          cpsr_d = entry_status;
          trap_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q <= RST_STATUS;
      trap_q <= '0;
    end else begin
      cpsr_q <= cpsr_d;
      trap_q <= trap_d;
    end
  end

  assign raw_target = (cause == CS_RET) ? lr_rd
                                        : VEC_BASE + XLEN'({cause, 2'b00});

  assign redirect_o     = take;
  assign cause_o        = cause;
  assign target_o       = {raw_target[XLEN-1:2], 2'b00};
  assign status_o       = cpsr_q;
  assign saved_status_o = spsr_rd;
  assign link_o         = lr_rd;
  assign trap_num_o     = trap_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [XLEN-1:0]  pc_i,
  input logic             redirect_o,
  input logic [3:0]       cause_o,
  input logic [XLEN-1:0]  target_o,
  input logic [XLEN-1:0]  status_o,
  input logic [XLEN-1:0]  saved_status_o,
  input logic [XLEN-1:0]  link_o,
  input logic [IMM_W-1:0] trap_num_o
);
  AST_TARGET_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> target_o[1:0] == 2'b00); // R12

  AST_IDLE_NO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> cause_o == 4'd15); // R2

  AST_IRQ_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && cause_o == 4'd6) |-> !status_o[7]); // R3

  AST_FIQ_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && cause_o == 4'd7) |-> !status_o[6]); // R3

  AST_TRAP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && cause_o == 4'd2) |=>
      (status_o[4:0] == 5'h13 && status_o[7] &&
       saved_status_o == $past(status_o)));  // R5

  AST_TRAP_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && cause_o == 4'd2) |=>
      link_o == ({$past(pc_i[XLEN-1:2]), 2'b00} + XLEN'(4))); // R7

  AST_RESET_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && cause_o == 4'd0) |=> status_o == XLEN'(32'hD3)); // R8

  AST_RET_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && cause_o == 4'd8) |=> status_o == $past(saved_status_o)); // R9

  AST_TRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |=> $stable(trap_num_o)); // R11
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pc_i           (pc_i),
  .redirect_o     (redirect_o),
  .cause_o        (cause_o),
  .target_o       (target_o),
  .status_o       (status_o),
  .saved_status_o (saved_status_o),
  .link_o         (link_o),
  .trap_num_o     (trap_num_o)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_ni, rst_req, undef, pabt, dabt, irq, fiq, exec, ret, swe;
  logic [31:0] instr, pc, swd;
  logic        redirect;
  logic [3:0]  cause;
  logic [31:0] target, status, saved, link;
  logic [23:0] trap_num;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .rst_req_i(rst_req), .undef_i(undef),
    .pabt_i(pabt), .dabt_i(dabt), .irq_i(irq), .fiq_i(fiq), .exec_i(exec),
    .instr_i(instr), .pc_i(pc), .ret_i(ret), .status_we_i(swe),
    .status_wd_i(swd), .redirect_o(redirect), .cause_o(cause),
    .target_o(target), .status_o(status), .saved_status_o(saved),
    .link_o(link), .trap_num_o(trap_num)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_cpsr;
  logic [31:0] m_spsr [5];
  logic [31:0] m_lr   [5];
  logic [23:0] m_trap;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int bank_of(logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [4:0] mode_of(logic [3:0] c);
    case (c)
      4'd1: return 5'h1B;
      4'd3, 4'd4: return 5'h17;
      4'd6: return 5'h12;
      4'd7: return 5'h11;
      default: return 5'h13;
    endcase
  endfunction

  function automatic logic [3:0] pick_cause();
    if (rst_req) return 4'd0;
    if (dabt) return 4'd4;
    if (fiq && !m_cpsr[6]) return 4'd7;
    if (irq && !m_cpsr[7]) return 4'd6;
    if (pabt) return 4'd3;
    if (undef) return 4'd1;
    if (exec && instr[27:24] == 4'hF) return 4'd2;
    if (ret && bank_of(m_cpsr[4:0]) >= 0) return 4'd8;
    return 4'd15;
  endfunction

  task automatic clr_in();
    rst_req = 0; undef = 0; pabt = 0; dabt = 0; irq = 0; fiq = 0;
    exec = 0; ret = 0; swe = 0; instr = '0; pc = 32'h0000_2000; swd = '0;
  endtask

  task automatic step(string req);
    logic [3:0]  c;
    logic [31:0] t, ns;
    int          cur, b;
    #1;
    c   = pick_cause();
    cur = bank_of(m_cpsr[4:0]);
    if (c == 4'd8) t = m_lr[cur];
    else t = {28'd0, c} << 2;
    chk(req, "redirect", {31'd0, redirect}, {31'd0, c != 4'd15});
    chk(req, "cause", {28'd0, cause}, {28'd0, c});
    if (c != 4'd15) chk(req, "target", target, t);
    chk(req, "status", status, m_cpsr);
    chk(req, "saved", saved, (cur >= 0) ? m_spsr[cur] : 32'd0);
    chk(req, "link", link, (cur >= 0) ? m_lr[cur] : 32'd0);
    chk(req, "trap_num", {8'd0, trap_num}, {8'd0, m_trap});
    if (c == 4'd15) begin
      if (swe) m_cpsr = swd;
    end else if (c == 4'd8) begin
      m_cpsr = m_spsr[cur];
    end else if (c == 4'd0) begin
      m_cpsr = 32'hD3;
      m_trap = '0;
    end else begin
      b = bank_of(mode_of(c));
      m_spsr[b] = m_cpsr;
      m_lr[b]   = {pc[31:2], 2'b00} + 32'd4;
      ns = m_cpsr;
      ns[4:0] = mode_of(c);
      ns[7] = 1'b1;
      if (c == 4'd7) ns[6] = 1'b1;
      m_cpsr = ns;
      m_trap = (c == 4'd2) ? instr[23:0] : 24'd0;
    end
    @(posedge clk);
    @(negedge clk);
    clr_in();
  endtask

  task automatic rand_in();
    logic [31:0] r;
    logic [4:0]  modes [6];
    modes[0] = 5'h10; modes[1] = 5'h11; modes[2] = 5'h12;
    modes[3] = 5'h13; modes[4] = 5'h17; modes[5] = 5'h1B;
    rst_req = ($urandom_range(63) == 0);
    dabt    = ($urandom_range(15) == 0);
    pabt    = ($urandom_range(15) == 0);
    undef   = ($urandom_range(15) == 0);
    irq     = ($urandom_range(3) == 0);
    fiq     = ($urandom_range(7) == 0);
    exec    = ($urandom_range(1) == 0);
    instr   = $urandom();
    if ($urandom_range(2) == 0) instr[27:24] = 4'hF;
    pc      = $urandom();
    ret     = ($urandom_range(4) == 0);
    swe     = ($urandom_range(9) == 0);
    r       = $urandom();
    swd     = {r[31:8], r[7:5], modes[$urandom_range(5)]};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    clr_in();
    rst_ni = 1'b0;
    m_cpsr = 32'hD3;
    m_trap = '0;
    for (int i = 0; i < 5; i++) begin
      m_spsr[i] = '0;
      m_lr[i]   = '0;
    end
    repeat (2) @(negedge clk);
    chk("R13", "reset status", status, 32'hD3);
    chk("R13", "reset redirect", {31'd0, redirect}, 32'd0);
    chk("R13", "reset trap_num", {8'd0, trap_num}, 32'd0);
    chk("R13", "reset link", link, 32'd0);
    chk("R13", "reset saved", saved, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    swe = 1; swd = 32'h0000_0010; step("R5");
    exec = 1; instr = 32'hEF00_ABCD; pc = 32'h0000_1003; step("R4");
    step("R7");
    exec = 1; instr = 32'h0F12_3456; pc = 32'h0000_3000; undef = 0;
    m_cpsr = m_cpsr;
    ret = 1; step("R9");
    step("R9");
    ret = 1; step("R9");
    exec = 1; instr = 32'h0F12_3456; pc = 32'h0000_4000; step("R4");
    step("R11");
    ret = 1; step("R9");
    swe = 1; swd = 32'h0000_0090; step("R5");
    irq = 1; step("R3");
    swe = 1; swd = 32'h0000_0010; step("R5");
    irq = 1; pc = 32'h0000_5004; step("R6");
    step("R11");
    fiq = 1; ret = 1; pc = 32'h0000_6008; step("R10");
    step("R6");
    ret = 1; step("R9");
    ret = 1; step("R9");
    rst_req = 1; dabt = 1; pabt = 1; undef = 1; irq = 1; fiq = 1;
    exec = 1; instr = 32'hFF00_0001; ret = 1; step("R2");
    step("R8");
    dabt = 1; pc = 32'h0000_7007; step("R12");
    swe = 1; swd = 32'h0000_0010; undef = 1; pc = 32'h0000_8000; step("R10");
    step("R10");
    pabt = 1; step("R1");

    for (int k = 0; k < 3000; k++) begin
      rand_in();
      step("R1");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule